// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block sits behind the command/address pins of a DDR4-style memory device. On every rising clock edge it samples chip select, the activate strobe, the shared row-address/command pins, the address bus, the bank and bank-group inputs and clock enable. It turns them into one registered command strobe and the fields that command carries. The fields are row or column address, target bank, auto-precharge, burst chop, and the mode-register select with its opcode. The sampled fields are never passed through raw. Each one is steered to its output only when the decoded command gives it a meaning. In every other cycle it is driven to zero.

The decoder also keeps one open-row flag for each bank. The flags follow activates, single and all-bank precharges, and auto-precharging reads and writes. Together with clock enable they give a coarse power state: awake, precharge power-down with every bank idle, or active power-down with at least one row open. Everything appears one clock after the edge that sampled it.

Top module: `cmd_addr_decoder`

## Requirements
- R1: A synchronous active-high reset leaves the NOP strobe bit as the only strobe bit set, with the reserved flag low, all fields zero, the power state awake (0) and every bank flag clear.
- R2: When chip select is sampled high (with CKE high), the result is the NOP strobe and no bank flag changes.
- R3: With chip select low and the activate strobe low, the result is strobe bit 1 (activate). The row address is the full 18-bit address bus, and address bits 16, 15 and 14 supply row bits 16..14. Bank group and bank are reported, and that bank's flag (index {bank group, bank}) becomes set.
- R4: With the activate strobe high, address bits 16/15/14 are decoded as the row strobe, column strobe and write-enable pins, all active low. The codes are 000 mode register set (strobe bit 6), 001 refresh (bit 7), 010 precharge, 100 write (bit 3), 101 read (bit 2) and 111 NOP (bit 0).
- R5: The pin codes 011 and 110 set the reserved flag with an all-zero strobe, and they leave the bank flags unchanged. In every cycle exactly one of the reserved flag or a strobe bit is set.
- R6: On a read or write, address bit 10 high raises the auto-precharge output and clears the accessed bank's flag. Address bit 10 low leaves the flag set. The column output is address bits 9..0.
- R7: On a precharge, address bit 10 low gives strobe bit 4 and clears only the bank named by bank group and bank. Address bit 10 high gives strobe bit 5 and clears every flag.
- R8: On a read or write, address bit 12 low raises the burst-chop output, and address bit 12 high leaves it low.
- R9: On a mode register set, the register select output is {bank group, bank} and the opcode output is address bits 13..0.
- R10: The power state is 0 when CKE is sampled high. When CKE is sampled low it is 1 if no bank is open and 2 if any bank is open.
- R11: When CKE is sampled low, any command on the pins is ignored: the result is the NOP strobe and the bank flags are unchanged.
- R12: Outputs change exactly one clock after the sampling edge, and at most one strobe bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| addr | input | 18 | Address bus; bits 16..14 double as command pins |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank within group |
| cmd_strobe | output | 8 | One-hot decoded command |
| cmd_rsvd | output | 1 | Reserved encoding seen |
| row_addr | output | 18 | Row address of an activate |
| col_addr | output | 10 | Column address of a read or write |
| bank_grp | output | 2 | Target bank group |
| bank | output | 2 | Target bank |
| auto_pre | output | 1 | Auto precharge requested |
| burst_chop | output | 1 | Burst chop requested |
| mr_sel | output | 4 | Mode register select |
| mr_opcode | output | 14 | Mode register opcode |
| pwr_state | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down |
| bank_open | output | 16 | Open-row flag per bank |

## Verification
Two functions meet in one cycle here: the CKE mask, and the bank-flag update from a read with auto precharge. The bench drops CKE in the same cycle that it presents an auto-precharging read to an open bank. The scoreboard then expects the NOP strobe, the flag still set and the power state at active power-down. A second case presents the same read with CKE high and expects the flag cleared. The bank flags and the power classification meet in a similar way. Closing the last open bank and then dropping CKE must report precharge power-down, not active power-down.

// File: rtl/cad_pkg.sv
package cad_pkg;

    typedef enum logic [2:0] {
        K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_MRS, K_REF, K_RSV
    } cad_kind_e;

    typedef enum logic [1:0] {
        PWR_AWAKE  = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_ACT_PD = 2'd2
    } cad_pwr_e;

    localparam int S_NOP   = 0;
    localparam int S_ACT   = 1;
    localparam int S_RD    = 2;
    localparam int S_WR    = 3;
    localparam int S_PRESB = 4;
    localparam int S_PREAB = 5;
    localparam int S_MRS   = 6;
    localparam int S_REF   = 7;
    localparam int S_NUM   = 8;

endpackage

// File: rtl/cad_cmd_classify.sv
module cad_cmd_classify
    import cad_pkg::*;
(
    input  logic       cke,
    input  logic       cs_n,
    input  logic       act_n,
    input  logic [2:0] rcw,
    output cad_kind_e  kind
);

    // rcw = {row strobe, column strobe, write enable}, all active low
    always_comb begin
        if (!cke || cs_n) begin
            kind = K_NOP;
        end else if (!act_n) begin
            kind = K_ACT;
        end else begin
            case (rcw)
                3'b000:  kind = K_MRS;
                3'b001:  kind = K_REF;
                3'b010:  kind = K_PRE;
                3'b100:  kind = K_WR;
                3'b101:  kind = K_RD;
                3'b111:  kind = K_NOP;
                default: kind = K_RSV;
            endcase
        end
    end

endmodule

// File: rtl/cad_bank_tracker.sv
module cad_bank_tracker #(
    parameter  int IDX_W = 4,
    localparam int NB    = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] idx,
    output logic [NB-1:0]    open_q
);

    logic [NB-1:0] open_d;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic hit;
        assign hit = (idx == IDX_W'(g));
        assign open_d[g] = clr_all          ? 1'b0 :
                           (hit && set_en)  ? 1'b1 :
                           (hit && clr_en)  ? 1'b0 :
                                              open_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= '0;
        end else begin
            open_q <= open_d;
        end
    end

    AST_ACT_MARKS_OPEN: assert property (@(posedge clk) disable iff (rst)
        set_en |=> open_q[$past(idx)]);                              // R3
    AST_CLOSE_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en && !clr_all) |=> !open_q[$past(idx)]);    // R6
    AST_PREALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (open_q == '0));                                 // R7
    AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en && !clr_all) |=> $stable(open_q));       // R2

endmodule

// File: rtl/cmd_addr_decoder.sv
module cmd_addr_decoder
    import cad_pkg::*;
#(
    parameter  int ADDR_W = 18,
    parameter  int COL_W  = 10,
    parameter  int OPC_W  = 14,
    parameter  int BG_W   = 2,
    parameter  int BA_W   = 2,
    parameter  int AP_BIT = 10,
    parameter  int BC_BIT = 12,
    parameter  int PIN_LO = 14,
    localparam int IDX_W  = BG_W + BA_W,
    localparam int NB     = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              act_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BG_W-1:0]   bg,
    input  logic [BA_W-1:0]   ba,
    output logic [S_NUM-1:0]  cmd_strobe,
    output logic              cmd_rsvd,
    output logic [ADDR_W-1:0] row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic [BG_W-1:0]   bank_grp,
    output logic [BA_W-1:0]   bank,
    output logic              auto_pre,
    output logic              burst_chop,
    output logic [IDX_W-1:0]  mr_sel,
    output logic [OPC_W-1:0]  mr_opcode,
    output logic [1:0]        pwr_state,
    output logic [NB-1:0]     bank_open
);

    typedef struct packed {
        logic [S_NUM-1:0]  strobe;
        logic              rsvd;
        logic [ADDR_W-1:0] row;
        logic [COL_W-1:0]  col;
        logic [BG_W-1:0]   bg;
        logic [BA_W-1:0]   ba;
        logic              ap;
        logic              bc;
        logic [IDX_W-1:0]  msel;
        logic [OPC_W-1:0]  opc;
        cad_pwr_e          pwr;
    } dec_s;

    dec_s       dec_d, dec_q;
    cad_kind_e  kind;
    logic       a10;
    logic       trk_set, trk_clr, trk_all;
    logic [NB-1:0] open_q;

    assign a10 = addr[AP_BIT];

    cad_cmd_classify u_classify (
        .cke   (cke),
        .cs_n  (cs_n),
        .act_n (act_n),
        .rcw   (addr[PIN_LO+2:PIN_LO]),
        .kind  (kind)
    );

    always_comb begin
        trk_set = (kind == K_ACT);
        trk_clr = (((kind == K_RD) || (kind == K_WR)) && a10) ||
                  ((kind == K_PRE) && !a10);
        trk_all = (kind == K_PRE) && a10;
    end

    cad_bank_tracker #(.IDX_W(IDX_W)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .set_en  (trk_set),
        .clr_en  (trk_clr),
        .clr_all (trk_all),
        .idx     ({bg, ba}),
        .open_q  (open_q)
    );

    always_comb begin
        dec_d = '0;
        if (cke) begin
            dec_d.pwr = PWR_AWAKE;
        end else if (|open_q) begin
            dec_d.pwr = PWR_ACT_PD;
        end else begin
            dec_d.pwr = PWR_PRE_PD;
        end
        case (kind)
            K_ACT: begin
                dec_d.strobe[S_ACT] = 1'b1;
                dec_d.row           = addr;
                dec_d.bg            = bg;
                dec_d.ba            = ba;
            end
            K_RD, K_WR: begin
                if (kind == K_RD) dec_d.strobe[S_RD] = 1'b1;
                else              dec_d.strobe[S_WR] = 1'b1;
                dec_d.col = addr[COL_W-1:0];
                dec_d.bg  = bg;
                dec_d.ba  = ba;
                dec_d.ap  = a10;
                dec_d.bc  = !addr[BC_BIT];
            end
            K_PRE: begin
                if (a10) begin
                    dec_d.strobe[S_PREAB] = 1'b1;
                end else begin
                    dec_d.strobe[S_PRESB] = 1'b1;
                    dec_d.bg              = bg;
                    dec_d.ba              = ba;
                end
            end
            K_MRS: begin
                dec_d.strobe[S_MRS] = 1'b1;
                dec_d.msel          = {bg, ba};
                dec_d.opc           = addr[OPC_W-1:0];
            end
            K_REF:   dec_d.strobe[S_REF] = 1'b1;
            K_RSV:   dec_d.rsvd          = 1'b1;
            default: dec_d.strobe[S_NOP] = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q               <= '0;
            dec_q.strobe[S_NOP] <= 1'b1;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign cmd_strobe = dec_q.strobe;
    assign cmd_rsvd   = dec_q.rsvd;
    assign row_addr   = dec_q.row;
    assign col_addr   = dec_q.col;
    assign bank_grp   = dec_q.bg;
    assign bank       = dec_q.ba;
    assign auto_pre   = dec_q.ap;
    assign burst_chop = dec_q.bc;
    assign mr_sel     = dec_q.msel;
    assign mr_opcode  = dec_q.opc;
    assign pwr_state  = dec_q.pwr;
    assign bank_open  = open_q;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_strobe));                                         // R12
    AST_STROBE_XOR_RSVD: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_strobe, cmd_rsvd}) == 1);                      // R5
    AST_DESELECT_MASKS: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_strobe[S_NOP] && !cmd_rsvd));                    // R2
    AST_CKE_LOW_MASKS: assert property (@(posedge clk) disable iff (rst)
        !cke |=> (cmd_strobe[S_NOP] && pwr_state != PWR_AWAKE));       // R11
    AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cke && !cs_n && act_n && addr[PIN_LO+2:PIN_LO] == 3'b101 && a10)
        |=> (!bank_open[$past({bg, ba})] && auto_pre));                // R6

endmodule

// File: tb/cmd_addr_decoder_test.sv
module cmd_addr_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        act_n = 1'b1;
    logic [17:0] addr = '0;
    logic [1:0]  bg = '0;
    logic [1:0]  ba = '0;
    logic [7:0]  cmd_strobe;
    logic        cmd_rsvd;
    logic [17:0] row_addr;
    logic [9:0]  col_addr;
    logic [1:0]  bank_grp;
    logic [1:0]  bank;
    logic        auto_pre;
    logic        burst_chop;
    logic [3:0]  mr_sel;
    logic [13:0] mr_opcode;
    logic [1:0]  pwr_state;
    logic [15:0] bank_open;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmd_addr_decoder uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .act_n(act_n),
        .addr(addr), .bg(bg), .ba(ba),
        .cmd_strobe(cmd_strobe), .cmd_rsvd(cmd_rsvd), .row_addr(row_addr),
        .col_addr(col_addr), .bank_grp(bank_grp), .bank(bank),
        .auto_pre(auto_pre), .burst_chop(burst_chop), .mr_sel(mr_sel),
        .mr_opcode(mr_opcode), .pwr_state(pwr_state), .bank_open(bank_open)
    );

    typedef struct {
        logic [7:0]  st;
        logic        rs;
        logic [17:0] row;
        logic [9:0]  col;
        logic [1:0]  g;
        logic [1:0]  b;
        logic        ap;
        logic        bc;
        logic [3:0]  ms;
        logic [13:0] op;
        logic [1:0]  pw;
        logic [15:0] opn;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] m_open = '0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // driver: presents one sample and pushes what must appear after the edge
    task automatic issue(input logic k, input logic c, input logic a,
                         input logic [17:0] ad, input logic [1:0] gg,
                         input logic [1:0] bb, input string tag);
        exp_t e;
        logic [3:0] ix;
        @(negedge clk);
        cke = k; cs_n = c; act_n = a; addr = ad; bg = gg; ba = bb;
        e.st = '0; e.rs = 0; e.row = '0; e.col = '0; e.g = '0; e.b = '0;
        e.ap = 0; e.bc = 0; e.ms = '0; e.op = '0; e.tag = tag;
        ix = {gg, bb};
        e.pw = k ? 2'd0 : ((m_open != 0) ? 2'd2 : 2'd1);
        if (!k || c) begin
            e.st[0] = 1'b1;
        end else if (!a) begin
            e.st[1] = 1'b1; e.row = ad; e.g = gg; e.b = bb;
            m_open[ix] = 1'b1;
        end else begin
            case (ad[16:14])
                3'b000: begin e.st[6] = 1'b1; e.ms = ix; e.op = ad[13:0]; end
                3'b001: e.st[7] = 1'b1;
                3'b010: begin
                    if (ad[10]) begin
                        e.st[5] = 1'b1; m_open = '0;
                    end else begin
                        e.st[4] = 1'b1; e.g = gg; e.b = bb; m_open[ix] = 1'b0;
                    end
                end
                3'b100, 3'b101: begin
                    e.st[ad[14] ? 2 : 3] = 1'b1;
                    e.col = ad[9:0]; e.g = gg; e.b = bb;
                    e.ap = ad[10]; e.bc = !ad[12];
                    if (ad[10]) m_open[ix] = 1'b0;
                end
                3'b111: e.st[0] = 1'b1;
                default: e.rs = 1'b1;
            endcase
        end
        e.opn = m_open;
        sb.push_back(e);
    endtask

    // monitor: compares each pushed item 5 ns after the edge that registers it
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "strobe", 32'(cmd_strobe), 32'(e.st));
                chk(e.tag, "rsvd", 32'(cmd_rsvd), 32'(e.rs));
                chk(e.tag, "row", 32'(row_addr), 32'(e.row));
                chk(e.tag, "col", 32'(col_addr), 32'(e.col));
                chk(e.tag, "bank", 32'({bank_grp, bank}), 32'({e.g, e.b}));
                chk(e.tag, "ap", 32'(auto_pre), 32'(e.ap));
                chk(e.tag, "bc", 32'(burst_chop), 32'(e.bc));
                chk(e.tag, "mrsel", 32'(mr_sel), 32'(e.ms));
                chk(e.tag, "opcode", 32'(mr_opcode), 32'(e.op));
                chk(e.tag, "pwr", 32'(pwr_state), 32'(e.pw));
                chk(e.tag, "open", 32'(bank_open), 32'(e.opn));
            end
        end
    end

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic check_reset(input string tag);
        chk(tag, "rst strobe", 32'(cmd_strobe), 32'h1);
        chk(tag, "rst rsvd", 32'(cmd_rsvd), 32'h0);
        chk(tag, "rst pwr", 32'(pwr_state), 32'h0);
        chk(tag, "rst open", 32'(bank_open), 32'h0);
        chk(tag, "rst fields", 32'(row_addr) | 32'(col_addr) | 32'(mr_opcode), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset("R1");

        issue(1, 1, 1, 18'h0A5A5, 2'd1, 2'd1, "R2 deselect");
        issue(1, 0, 0, 18'h25A5C, 2'd1, 2'd2, "R3 activate upper pins");
        issue(1, 0, 0, 18'h1FFFF, 2'd0, 2'd0, "R3 activate all ones");
        issue(1, 1, 0, 18'h0C000, 2'd3, 2'd3, "R2 deselect over act");
        issue(1, 0, 1, 18'h14155, 2'd1, 2'd2, "R8 read chop R4");
        issue(1, 0, 1, 18'h112AA, 2'd0, 2'd0, "R8 write full R4");
        issue(1, 0, 1, 18'h04000, 2'd0, 2'd0, "R4 refresh");
        issue(1, 0, 1, 18'h1C000, 2'd2, 2'd1, "R4 nop");
        issue(1, 0, 1, 18'h0C000, 2'd1, 2'd0, "R5 reserved 011");
        issue(1, 0, 1, 18'h18400, 2'd0, 2'd0, "R5 reserved 110");
        issue(1, 0, 1, 18'h023A5, 2'd2, 2'd3, "R9 mode register");
        issue(0, 0, 1, 18'h14410, 2'd1, 2'd2, "R11 cke low masks R10");
        issue(1, 0, 1, 18'h14410, 2'd1, 2'd2, "R6 read autopre");
        issue(1, 0, 1, 18'h11400, 2'd0, 2'd0, "R6 write autopre");
        issue(0, 1, 1, 18'h1C000, 2'd0, 2'd0, "R10 idle power-down");
        issue(1, 0, 0, 18'h00123, 2'd3, 2'd1, "R3 open bank 13");
        issue(1, 0, 0, 18'h00456, 2'd2, 2'd2, "R3 open bank 10");
        issue(1, 0, 0, 18'h00789, 2'd0, 2'd3, "R3 open bank 3");
        issue(1, 0, 1, 18'h08000, 2'd2, 2'd2, "R7 precharge single");
        issue(0, 1, 1, 18'h1C000, 2'd0, 2'd0, "R10 active power-down");
        issue(1, 0, 1, 18'h08400, 2'd1, 2'd1, "R7 precharge all");
        issue(1, 0, 0, 18'h3FFFF, 2'd3, 2'd3, "R12 back-to-back act");
        issue(1, 0, 1, 18'h14000, 2'd3, 2'd3, "R12 back-to-back read");

        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_open = '0;
        check_reset("R1 after activity");
        issue(0, 1, 1, 18'h0, 2'd0, 2'd0, "R10 after reset");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule